// File: doc/BRIEF.md
# Rotate and Wrap-Around Mask Generator

This block is the shifting front end of a rotate-and-mask integer unit. It produces two results. The first is a left rotation of a 64-bit operand. The second is a 64-bit field mask. A later stage (not part of this block) combines the two to extract or insert bit fields.

In doubleword mode the whole operand rotates by a 6-bit amount. In word mode the low 32 bits of the operand are placed in both halves of a 64-bit value, and that value is rotated. Because of this, a word result appears identically in the upper and lower halves.

The mask is described by a begin index and an end index, both counted from the most significant bit. When the begin index is greater than the end index, the ones run past bit 63 and continue from bit 0. The same mode input moves both mask indices into the lower word. Both results are registered, so they appear one clock after the inputs are sampled.

Top module: `rotmask_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, both `rot_out` and `mask_out` become zero on that edge.
- R2: Both outputs are registered. Inputs sampled at a rising edge with `rst` low are reflected on the outputs right after that edge and held until the next one.
- R3: With `word_mode` = 0, `rot_out` is `src` rotated left by `amt` (0 to 63). Bits leaving the top re-enter at bit 0. For example, 0xDEADBEEF12345678 rotated by 10 gives 0xB6FBBC48D159E37A, and rotated by 35 gives 0x91A2B3C6F56DF778.
- R4: With `word_mode` = 1, `src[31:0]` is copied into both halves and that 64-bit value is rotated left by `amt` modulo 32. `src[63:32]` and `amt[5]` have no effect on `rot_out`.
- R5: Mask indices count from the MSB. Index 0 is `mask_out[63]` and index 63 is `mask_out[0]`.
- R6: With `word_mode` = 0 and `mask_begin` ≤ `mask_end`, `mask_out` has ones at indices `mask_begin` through `mask_end` inclusive, and zeros elsewhere. For example, begin 37 and end 63 give 0x0000000007FFFFFF, and begin 0 and end 37 give 0xFFFFFFFFFC000000.
- R7: With `word_mode` = 0 and `mask_begin` > `mask_end`, `mask_out` has ones at indices 0 through `mask_end` and at indices `mask_begin` through 63, and zeros elsewhere. For example, begin 47 and end 37 give 0xFFFFFFFFFC01FFFF.
- R8: With `word_mode` = 1, each mask index is replaced by 32 plus its low 5 bits, and the rules of R6 and R7 are then applied. Bit 5 of each index is ignored. For example, begin 5 and end 15 give 0x0000000007FF0000, and begin 0 and end 0 give 0x0000000080000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | 1 = 32-bit rotate and mask, 0 = 64-bit |
| src | input | 64 | Operand to rotate |
| amt | input | 6 | Left rotate amount |
| mask_begin | input | 6 | First mask index, counted from the MSB |
| mask_end | input | 6 | Last mask index, counted from the MSB |
| rot_out | output | 64 | Registered rotate result |
| mask_out | output | 64 | Registered mask |

## Verification
The bench builds the block with the default width of 64, which gives a 6-bit amount and 6-bit indices. At this size every rotate amount and every begin/end index pair can be applied directly in both modes. This covers the index equality and wrap-around edges, the word-mode folding of the high index bit, and the full range of amounts on several random operands. The fixed vectors from the requirements anchor the bit ordering.

// File: rtl/rotmask_pkg.sv
package rotmask_pkg;
  typedef enum logic {
    RM_DWORD = 1'b0,
    RM_WORD  = 1'b1
  } rm_mode_e;
endpackage

// File: rtl/rm_rotator.sv
module rm_rotator #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            word_mode,
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  amt,
  output logic [XLEN-1:0] rot
);
  import rotmask_pkg::*;
  localparam int HALF = XLEN / 2;
  localparam logic [SHW-1:0] LO_AMT = SHW'(HALF - 1);

  logic [XLEN-1:0]   opnd;
  logic [SHW-1:0]    n;
  logic [2*XLEN-1:0] wide;

  always_comb begin
    if (rm_mode_e'(word_mode) == RM_WORD) begin
      opnd = {src[HALF-1:0], src[HALF-1:0]};
      n    = amt & LO_AMT;
    end else begin
      opnd = src;
      n    = amt;
    end
    // upper half of the shifted doubled value is the rotation
    wide = {opnd, opnd} << n;
    rot  = wide[2*XLEN-1:XLEN];
  end
endmodule

// File: rtl/rm_index_map.sv
module rm_index_map #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic           word_mode,
  input  logic [SHW-1:0] idx_in,
  output logic [SHW-1:0] idx_out
);
  localparam int HALF = XLEN / 2;
  localparam logic [SHW-1:0] HALF_IDX = SHW'(HALF);
  localparam logic [SHW-1:0] LO_IDX   = SHW'(HALF - 1);

  // HALF is a power of two, so the offset is a single OR
  assign idx_out = word_mode ? (HALF_IDX | (idx_in & LO_IDX)) : idx_in;
endmodule

// File: rtl/rm_maskgen.sv
module rm_maskgen #(
  parameter int XLEN = 64,
  parameter int SHW  = $clog2(XLEN)
) (
  input  logic            word_mode,
  input  logic [SHW-1:0]  mb,
  input  logic [SHW-1:0]  me,
  output logic [XLEN-1:0] mask
);
  logic [SHW-1:0] b_eff;
  logic [SHW-1:0] e_eff;
  logic           wrap;

  rm_index_map #(.XLEN(XLEN), .SHW(SHW)) u_map_b (
    .word_mode(word_mode), .idx_in(mb), .idx_out(b_eff)
  );
  rm_index_map #(.XLEN(XLEN), .SHW(SHW)) u_map_e (
    .word_mode(word_mode), .idx_in(me), .idx_out(e_eff)
  );

  assign wrap = b_eff > e_eff;

  // position p counts from the MSB, so it drives mask[XLEN-1-p]
  for (genvar p = 0; p < XLEN; p++) begin : g_bit
    logic ge_b;
    logic le_e;
    assign ge_b = SHW'(p) >= b_eff;
    assign le_e = SHW'(p) <= e_eff;
    assign mask[XLEN-1-p] = wrap ? (ge_b | le_e) : (ge_b & le_e);
  end
endmodule

// File: rtl/rotmask_unit.sv
module rotmask_unit #(
  parameter  int XLEN = 64,
  localparam int SHW  = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            word_mode,
  input  logic [XLEN-1:0] src,
  input  logic [SHW-1:0]  amt,
  input  logic [SHW-1:0]  mask_begin,
  input  logic [SHW-1:0]  mask_end,
  output logic [XLEN-1:0] rot_out,
  output logic [XLEN-1:0] mask_out
);
  logic [XLEN-1:0] rot_d;
  logic [XLEN-1:0] mask_d;

  rm_rotator #(.XLEN(XLEN), .SHW(SHW)) u_rot (
    .word_mode(word_mode), .src(src), .amt(amt), .rot(rot_d)
  );

  rm_maskgen #(.XLEN(XLEN), .SHW(SHW)) u_mask (
    .word_mode(word_mode), .mb(mask_begin), .me(mask_end), .mask(mask_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rot_out  <= '0;
      mask_out <= '0;
    end else begin
      rot_out  <= rot_d;
      mask_out <= mask_d;
    end
  end
endmodule

// File: rtl/rotmask_unit_chk.sv
module rotmask_unit_chk #(
  parameter  int XLEN = 64,
  localparam int SHW  = $clog2(XLEN)
) (
  input logic            clk,
  input logic            rst,
  input logic            word_mode,
  input logic [XLEN-1:0] src,
  input logic [SHW-1:0]  amt,
  input logic [SHW-1:0]  mask_begin,
  input logic [SHW-1:0]  mask_end,
  input logic [XLEN-1:0] rot_out,
  input logic [XLEN-1:0] mask_out
);
  localparam int HALF = XLEN / 2;

  logic [XLEN-1:0] src_q;
  logic [SHW-1:0]  pos_b_q;
  logic [SHW-1:0]  pos_e_q;
  int              span_q;

  always_ff @(posedge clk) begin
    src_q   <= src;
    pos_b_q <= SHW'(XLEN - 1) - mask_begin;
    pos_e_q <= SHW'(XLEN - 1) - mask_end;
    span_q  <= int'(mask_end) - int'(mask_begin) + 1;
  end

  // R3: amount zero leaves the operand unchanged
  a_r3_zero_amt_identity: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && amt == '0) |=> rot_out == src_q);

  // R3: rotation neither creates nor loses ones
  a_r3_popcount_kept: assert property (@(posedge clk) disable iff (rst)
    !word_mode |=> $countones(rot_out) == $countones(src_q));

  // R4: word results are the same in both halves
  a_r4_halves_equal: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> rot_out[XLEN-1:HALF] == rot_out[HALF-1:0]);

  // R4: word result holds two copies of the low word's ones
  a_r4_word_popcount: assert property (@(posedge clk) disable iff (rst)
    word_mode |=> $countones(rot_out) == 2 * $countones(src_q[HALF-1:0]));

  // R5, R6, R7: both end indices are always inside the mask
  a_r6_ends_set: assert property (@(posedge clk) disable iff (rst)
    !word_mode |=> (mask_out[pos_b_q] && mask_out[pos_e_q]));

  // R6: a non-wrapping mask is exactly end-begin+1 ones
  a_r6_span_count: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && mask_begin <= mask_end) |=> $countones(mask_out) == span_q);

  // R7: a wrapping mask covers both word extremes
  a_r7_wrap_extremes: assert property (@(posedge clk) disable iff (rst)
    (!word_mode && mask_begin > mask_end) |=> (mask_out[XLEN-1] && mask_out[0]));

  // R8: a non-wrapping word mask stays in the low word
  a_r8_word_upper_clear: assert property (@(posedge clk) disable iff (rst)
    (word_mode && mask_begin[SHW-2:0] <= mask_end[SHW-2:0])
      |=> mask_out[XLEN-1:HALF] == '0);
endmodule

bind rotmask_unit rotmask_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk(clk), .rst(rst), .word_mode(word_mode), .src(src), .amt(amt),
  .mask_begin(mask_begin), .mask_end(mask_end),
  .rot_out(rot_out), .mask_out(mask_out)
);

// File: tb/rotmask_unit_tb.sv
`timescale 1ns/1ps
module rotmask_unit_tb;
  localparam int XLEN = 64;
  localparam int WATCHDOG_CYCLES = 200000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_mode = 1'b0;
  logic [63:0] src = 64'hFFFF_0000_AAAA_5555;
  logic [5:0]  amt = 6'd3;
  logic [5:0]  mask_begin = 6'd1;
  logic [5:0]  mask_end = 6'd9;
  logic [63:0] rot_out;
  logic [63:0] mask_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  rotmask_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst(rst), .word_mode(word_mode), .src(src), .amt(amt),
    .mask_begin(mask_begin), .mask_end(mask_end),
    .rot_out(rot_out), .mask_out(mask_out)
  );

  function automatic logic [63:0] ref_rotl(input logic [63:0] x, input int n);
    int k = n % 64;
    if (k == 0) return x;
    return (x << k) | (x >> (64 - k));
  endfunction

  // index p counts from the MSB
  function automatic logic [63:0] ref_mask(input int b, input int e);
    logic [63:0] m = '0;
    for (int p = 0; p < 64; p++) begin
      if (b <= e) begin
        if (p >= b && p <= e) m[63-p] = 1'b1;
      end else begin
        if (p <= e || p >= b) m[63-p] = 1'b1;
      end
    end
    return m;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive on a falling edge, sample on the next falling edge (one register)
  task automatic apply(input logic w, input logic [63:0] s, input int a,
                       input int b, input int e);
    @(negedge clk);
    word_mode  = w;
    src        = s;
    amt        = 6'(a);
    mask_begin = 6'(b);
    mask_end   = 6'(e);
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    apply(1'b0, 64'h0123_4567_89AB_CDEF, 5, 2, 40);
    chk("R1 rot under reset", rot_out, 64'h0);
    chk("R1 mask under reset", mask_out, 64'h0);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_latency();
    apply(1'b0, 64'h1, 1, 0, 0);
    chk("R2 rot after one edge", rot_out, 64'h2);
    chk("R2 mask after one edge", mask_out, 64'h8000_0000_0000_0000);
    @(negedge clk);
    chk("R2 rot held", rot_out, 64'h2);
  endtask

  task automatic t_rot_vectors();
    apply(1'b0, 64'hDEADBEEF12345678, 10, 0, 63);
    chk("R3 rotl 10", rot_out, 64'hB6FBBC48D159E37A);
    apply(1'b0, 64'hDEADBEEF12345678, 35, 0, 63);
    chk("R3 rotl 35", rot_out, 64'h91A2B3C6F56DF778);
    apply(1'b0, 64'h8000_0000_0000_0001, 63, 0, 63);
    chk("R3 rotl 63", rot_out, 64'hC000_0000_0000_0000);
  endtask

  task automatic t_rot_sweep();
    for (int r = 0; r < 4; r++) begin
      logic [63:0] v = {$urandom, $urandom};
      for (int a = 0; a < 64; a++) begin
        apply(1'b0, v, a, 0, 63);
        chk($sformatf("R3 sweep amt=%0d", a), rot_out, ref_rotl(v, a));
      end
    end
  endtask

  task automatic t_word_rot();
    for (int r = 0; r < 3; r++) begin
      logic [63:0] v = {$urandom, $urandom};
      logic [63:0] dup = {v[31:0], v[31:0]};
      for (int a = 0; a < 64; a++) begin
        apply(1'b1, v, a, 0, 31);
        chk($sformatf("R4 word amt=%0d", a), rot_out, ref_rotl(dup, a % 32));
      end
    end
    apply(1'b1, 64'hFFFF_FFFF_0000_0001, 1, 0, 0);
    chk("R4 upper src ignored", rot_out, 64'h0000_0002_0000_0002);
  endtask

  task automatic t_mask_dword();
    apply(1'b0, 64'h0, 0, 37, 63);
    chk("R6 mask 37..63", mask_out, 64'h0000_0000_07FF_FFFF);
    apply(1'b0, 64'h0, 0, 0, 37);
    chk("R6 mask 0..37", mask_out, 64'hFFFF_FFFF_FC00_0000);
    apply(1'b0, 64'h0, 0, 47, 37);
    chk("R7 mask wrap 47,37", mask_out, 64'hFFFF_FFFF_FC01_FFFF);
    apply(1'b0, 64'h0, 0, 63, 63);
    chk("R5 index 63 is bit 0", mask_out, 64'h1);
    for (int b = 0; b < 64; b++) begin
      for (int e = 0; e < 64; e++) begin
        apply(1'b0, 64'h0, 0, b, e);
        chk($sformatf("%s b=%0d e=%0d", (b <= e) ? "R6" : "R7", b, e),
            mask_out, ref_mask(b, e));
      end
    end
  endtask

  task automatic t_mask_word();
    apply(1'b1, 64'h0, 0, 5, 15);
    chk("R8 word mask 5..15", mask_out, 64'h0000_0000_07FF_0000);
    apply(1'b1, 64'h0, 0, 0, 0);
    chk("R8 word mask 0..0", mask_out, 64'h0000_0000_8000_0000);
    apply(1'b1, 64'h0, 0, 15, 5);
    chk("R8 word mask wrap", mask_out, 64'hFFFF_FFFF_FC01_FFFF);
    for (int b = 0; b < 64; b++) begin
      for (int e = 0; e < 64; e++) begin
        apply(1'b1, 64'h0, 0, b, e);
        chk($sformatf("R8 word b=%0d e=%0d", b, e), mask_out,
            ref_mask(32 + (b % 32), 32 + (e % 32)));
      end
    end
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    t_reset();
    t_latency();
    t_rot_vectors();
    t_rot_sweep();
    t_word_rot();
    t_mask_dword();
    t_mask_word();
    t_reset();
    done = 1'b1;
    summary();
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end
endmodule